// File: doc/BRIEF.md
# RV64 Integer ALU with Bit-Manipulation Operations

This block is the integer execution datapath of a 64-bit core. It takes two 64-bit source operands and a 7-bit operation code, and one clock later it presents a 64-bit result and a branch-taken flag. It covers full-width shifts and rotates, single-bit clear, set, invert and extract, 32-bit word forms that sign-extend their result, fused address forms (shift-then-add, add with a right-shifted high source, add of a zero-extended low word), compares with min and max, logic with an inverted operand, per-byte OR-combine, bit and byte reversal, packing, and logic whose result is narrowed to one bit or to a halfword.

The upper three opcode bits select an operation group. Four sub-units each evaluate their group in parallel, and the top picks one sub-unit result by group. Branch opcodes produce a zero result, and their compare type and polarity come straight from opcode bits. The outputs are registered behind a synchronous active-high reset, so results appear exactly one cycle after the operands.

Top module: `rv_bitalu`

## Requirements
- R1: `alu_res` and `br_taken` are registered. While `rst` is high they go to zero at each clock edge. Otherwise they take, at each rising edge, the value computed from the operands and opcode present before that edge.
- R2: Shifts and rotates of the full 64 bits use only `src_b[5:0]` as the amount: slliuw 0000000 (zero-extended `src_a[31:0]` shifted left), sll 0000001, srl 0000101, sra 0000111, rol 0001001, ror 0001011.
- R3: Single-bit ops take the index from `src_b[5:0]`: bclr 0000010 clears bit idx of `src_a`, bset 0000011 sets it, binv 0000100 flips it, bext 0000110 returns that bit in bit 0 with the upper bits zero.
- R4: Word ops compute a 32-bit value and sign-extend its bit 31 to 64 bits, with shift amounts taken from `src_b[4:0]`: addw 0010000, oddaddw 0010001 (`src_a[0]` + `src_b`), subw 0010010, sllw 0011000, srlw 0011001 and sraw 0011010 (both shift `src_a[31:0]`), rolw 0011100 and rorw 0011101 (rotate the low word).
- R5: Narrowed word adds of `src_a + src_b`: addwbit 0010100 gives bit 0 only, addwbyte 0010101 the zero-extended low byte, addwzexth 0010110 the zero-extended low halfword, and addwsexth 0010111 the sign-extended low halfword.
- R6: Add forms: adduw 0100000 adds the zero-extended `src_a[31:0]` to `src_b`, add 0100001 is `src_a + src_b`, oddadd 0100010 is `src_a[0] + src_b`, and codes 0100100 to 0100111 give `(src_a >> N) + src_b` for N = 29, 30, 31 and 32 respectively.
- R7: Shift-then-add: sh1add 0101001, sh2add 0101011, sh3add 0101101 and sh4add 0101111 give `(src_a << N) + src_b`. The word variants sh1adduw 0101000, sh2adduw 0101010 and sh3adduw 0101100 shift the zero-extended `src_a[31:0]` instead.
- R8: Compare group: sub 0110000, sltu 0110001 and slt 0110010 (0 or 1 in bit 0), maxu 0110100, minu 0110101, max 0110110 and min 0110111. Signed forms use two's complement.
- R9: Logic: and 1000000, andn 1000001 (`src_a & ~src_b`), or 1000010, orn 1000011, xor 1000100, xnor 1000101, and orcb 1000110. orcb turns each byte of `src_a` into 0xFF if it is nonzero and into 0x00 if it is zero.
- R10: Misc: sextb 1001000 and sexth 1001010 sign-extend the low byte or halfword of `src_a`. packh 1001001 zero-extends {`src_b[7:0]`,`src_a[7:0]`}, packw 1001011 sign-extends {`src_b[15:0]`,`src_a[15:0]`}, and pack 1010010 gives {`src_b[31:0]`,`src_a[31:0]`}. revb 1010000 reverses the bits inside each byte, and rev8 1010001 reverses the byte order.
- R11: Codes 1100xxx apply the function chosen by opcode bits [2:1] (00 and, 01 or, 10 xor, 11 orcb of `src_a`). Opcode bit 0 = 0 keeps bit 0 only, and bit 0 = 1 keeps the zero-extended low 16 bits.
- R12: Opcodes with bits [6:4] = 111 give a zero result. For the branch codes, bits [3:2] pick the compare (00 equal, 10 signed less-than, 11 unsigned less-than) and bit 1 inverts the outcome: beq 1110000, bne 1110010, blt 1111000, bge 1111010, bltu 1111100, bgeu 1111110.
- R13: Any opcode not listed above gives a zero result and `br_taken` = 0. Every non-branch opcode gives `br_taken` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand, also the shift amount or bit index |
| op_code | input | 7 | Operation code; bits [6:4] select the group |
| alu_res | output | 64 | Registered result |
| br_taken | output | 1 | Registered branch outcome |

## Verification
The assertions assume that reset is held high for at least one rising edge before operation, and that inputs are never X after reset. The bench drives every input at the falling edge, with reset held high from time zero and zero operands during reset. For the min/max and width properties, the checker relates each registered output to the opcode and operands sampled one edge earlier, so it needs the inputs to be stable across each rising edge. Drawing each stimulus once per cycle away from the edge guarantees that.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned OPW    = 7;
  localparam int unsigned WLEN   = XLEN / 2;
  localparam int unsigned SHW    = $clog2(XLEN);
  localparam int unsigned WSHW   = $clog2(WLEN);
  localparam int unsigned NBYTES = XLEN / 8;

  typedef enum logic [2:0] {
    GRP_SHIFT  = 3'b000,
    GRP_WORD   = 3'b001,
    GRP_ADD    = 3'b010,
    GRP_CMP    = 3'b011,
    GRP_LOGIC  = 3'b100,
    GRP_MISC   = 3'b101,
    GRP_NARROW = 3'b110,
    GRP_BRANCH = 3'b111
  } alu_grp_e;

  function automatic logic [XLEN-1:0] sext_w(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){v[WLEN-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zext_w(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){1'b0}}, v};
  endfunction
endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [SHW-1:0]  amt,
  input  logic [3:0]      sub_op,
  output logic [XLEN-1:0] res
);
  logic [2*XLEN-1:0] dbl_l, dbl_r;
  logic [XLEN-1:0]   onehot;

  assign dbl_l  = {a, a} << amt;
  assign dbl_r  = {a, a} >> amt;
  assign onehot = {{(XLEN-1){1'b0}}, 1'b1} << amt;

  always_comb begin
    case (sub_op)
      4'b0000: res = zext_w(a[WLEN-1:0]) << amt;
      4'b0001: res = a << amt;
      4'b0010: res = a & ~onehot;
      4'b0011: res = a | onehot;
      4'b0100: res = a ^ onehot;
      4'b0101: res = a >> amt;
      4'b0110: res = {{(XLEN-1){1'b0}}, a[amt]};
      4'b0111: res = $signed(a) >>> amt;
      4'b1001: res = dbl_l[2*XLEN-1:XLEN];
      4'b1011: res = dbl_r[XLEN-1:0];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            is_word,
  input  logic [3:0]      sub_op,
  output logic [XLEN-1:0] res
);
  logic [WSHW-1:0]   wamt;
  logic [WLEN-1:0]   a_lo, b_lo, wsum, wdiff, wodd, wsll, wsrl, wsra;
  logic [2*WLEN-1:0] wrl, wrr;
  logic [XLEN-1:0]   a_uw, word_res, add_res;

  assign wamt  = b[WSHW-1:0];
  assign a_lo  = a[WLEN-1:0];
  assign b_lo  = b[WLEN-1:0];
  assign wsum  = a_lo + b_lo;
  assign wdiff = a_lo - b_lo;
  assign wodd  = {{(WLEN-1){1'b0}}, a[0]} + b_lo;
  assign wsll  = a_lo << wamt;
  assign wsrl  = a_lo >> wamt;
  assign wsra  = $signed(a_lo) >>> wamt;
  assign wrl   = {a_lo, a_lo} << wamt;
  assign wrr   = {a_lo, a_lo} >> wamt;
  assign a_uw  = zext_w(a_lo);

  always_comb begin
    case (sub_op)
      4'b0000: word_res = sext_w(wsum);
      4'b0001: word_res = sext_w(wodd);
      4'b0010: word_res = sext_w(wdiff);
      4'b0100: word_res = {{(XLEN-1){1'b0}}, wsum[0]};
      4'b0101: word_res = {{(XLEN-8){1'b0}}, wsum[7:0]};
      4'b0110: word_res = {{(XLEN-16){1'b0}}, wsum[15:0]};
      4'b0111: word_res = {{(XLEN-16){wsum[15]}}, wsum[15:0]};
      4'b1000: word_res = sext_w(wsll);
      4'b1001: word_res = sext_w(wsrl);
      4'b1010: word_res = sext_w(wsra);
      4'b1100: word_res = sext_w(wrl[2*WLEN-1:WLEN]);
      4'b1101: word_res = sext_w(wrr[WLEN-1:0]);
      default: word_res = '0;
    endcase
  end

  always_comb begin
    case (sub_op)
      4'b0000: add_res = a_uw + b;
      4'b0001: add_res = a + b;
      4'b0010: add_res = {{(XLEN-1){1'b0}}, a[0]} + b;
      4'b0100: add_res = (a >> 29) + b;
      4'b0101: add_res = (a >> 30) + b;
      4'b0110: add_res = (a >> 31) + b;
      4'b0111: add_res = (a >> 32) + b;
      4'b1000: add_res = (a_uw << 1) + b;
      4'b1001: add_res = (a << 1) + b;
      4'b1010: add_res = (a_uw << 2) + b;
      4'b1011: add_res = (a << 2) + b;
      4'b1100: add_res = (a_uw << 3) + b;
      4'b1101: add_res = (a << 3) + b;
      4'b1111: add_res = (a << 4) + b;
      default: add_res = '0;
    endcase
  end

  assign res = is_word ? word_res : add_res;
endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            is_branch,
  input  logic [3:0]      sub_op,
  output logic [XLEN-1:0] res,
  output logic            taken
);
  logic eq, lts, ltu, raw;

  assign eq  = (a == b);
  assign lts = $signed(a) < $signed(b);
  assign ltu = a < b;

  always_comb begin
    case (sub_op)
      4'b0000: res = a - b;
      4'b0001: res = {{(XLEN-1){1'b0}}, ltu};
      4'b0010: res = {{(XLEN-1){1'b0}}, lts};
      4'b0100: res = ltu ? b : a;
      4'b0101: res = ltu ? a : b;
      4'b0110: res = lts ? b : a;
      4'b0111: res = lts ? a : b;
      default: res = '0;
    endcase
  end

  always_comb begin
    case (sub_op[3:2])
      2'b00:   raw = eq;
      2'b10:   raw = lts;
      2'b11:   raw = ltu;
      default: raw = 1'b0;
    endcase
    taken = is_branch && !sub_op[0] && (sub_op[3:2] != 2'b01) && (raw ^ sub_op[1]);
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      lgrp,
  input  logic [3:0]      sub_op,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] orcb_v, rev8_v, revb_v, nar_v;
  logic [XLEN-1:0] grp0_res, grp1_res;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign orcb_v[8*i +: 8] = {8{|a[8*i +: 8]}};
    assign rev8_v[8*i +: 8] = a[8*(NBYTES-1-i) +: 8];
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign revb_v[8*i + j] = a[8*i + 7 - j];
    end
  end

  always_comb begin
    case (sub_op)
      4'b0000: grp0_res = a & b;
      4'b0001: grp0_res = a & ~b;
      4'b0010: grp0_res = a | b;
      4'b0011: grp0_res = a | ~b;
      4'b0100: grp0_res = a ^ b;
      4'b0101: grp0_res = ~(a ^ b);
      4'b0110: grp0_res = orcb_v;
      4'b1000: grp0_res = {{(XLEN-8){a[7]}}, a[7:0]};
      4'b1001: grp0_res = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};
      4'b1010: grp0_res = {{(XLEN-16){a[15]}}, a[15:0]};
      4'b1011: grp0_res = sext_w({b[15:0], a[15:0]});
      default: grp0_res = '0;
    endcase
  end

  always_comb begin
    case (sub_op)
      4'b0000: grp1_res = revb_v;
      4'b0001: grp1_res = rev8_v;
      4'b0010: grp1_res = {b[WLEN-1:0], a[WLEN-1:0]};
      default: grp1_res = '0;
    endcase
  end

  always_comb begin
    case (sub_op[2:1])
      2'b00:   nar_v = a & b;
      2'b01:   nar_v = a | b;
      2'b10:   nar_v = a ^ b;
      default: nar_v = orcb_v;
    endcase
  end

  always_comb begin
    case (lgrp)
      2'b00: res = grp0_res;
      2'b01: res = grp1_res;
      2'b10: begin
        if (sub_op[3])      res = '0;
        else if (sub_op[0]) res = {{(XLEN-16){1'b0}}, nar_v[15:0]};
        else                res = {{(XLEN-1){1'b0}}, nar_v[0]};
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rv_bitalu.sv
module rv_bitalu
  import alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [OPW-1:0]  op_code,
  output logic [XLEN-1:0] alu_res,
  output logic            br_taken
);
  alu_grp_e        grp;
  logic [3:0]      sub_op;
  logic [XLEN-1:0] shift_res, arith_res, cmp_res, logic_res, res_nxt;
  logic            cmp_taken;

  assign grp    = alu_grp_e'(op_code[6:4]);
  assign sub_op = op_code[3:0];

  alu_shift_unit u_shift (
    .a(src_a), .amt(src_b[SHW-1:0]), .sub_op(sub_op), .res(shift_res)
  );

  alu_arith_unit u_arith (
    .a(src_a), .b(src_b), .is_word(grp == GRP_WORD), .sub_op(sub_op), .res(arith_res)
  );

  alu_cmp_unit u_cmp (
    .a(src_a), .b(src_b), .is_branch(grp == GRP_BRANCH), .sub_op(sub_op),
    .res(cmp_res), .taken(cmp_taken)
  );

  alu_logic_unit u_logic (
    .a(src_a), .b(src_b), .lgrp(op_code[5:4]), .sub_op(sub_op), .res(logic_res)
  );

  always_comb begin
    case (grp)
      GRP_SHIFT:                       res_nxt = shift_res;
      GRP_WORD, GRP_ADD:               res_nxt = arith_res;
      GRP_CMP:                         res_nxt = cmp_res;
      GRP_LOGIC, GRP_MISC, GRP_NARROW: res_nxt = logic_res;
      default:                         res_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alu_res  <= '0;
      br_taken <= 1'b0;
    end else begin
      alu_res  <= res_nxt;
      br_taken <= cmp_taken;
    end
  end
endmodule

// File: rtl/rv_bitalu_checker.sv
module rv_bitalu_checker
  import alu_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [OPW-1:0]  op_code,
  input logic [XLEN-1:0] alu_res,
  input logic            br_taken
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (alu_res == '0 && !br_taken));

  assert_word_sext_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code[6:4]) == 3'b001)
      |-> (alu_res[XLEN-1:WLEN] == {(XLEN-WLEN){alu_res[WLEN-1]}}));

  assert_addwbit_width_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 7'b0010100) |-> (alu_res[XLEN-1:1] == '0));

  assert_minmax_pick_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code[6:2]) == 5'b01101)
      |-> (alu_res == $past(src_a) || alu_res == $past(src_b)));

  assert_narrow_width_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code[6:4]) == 3'b110) |-> (alu_res[XLEN-1:16] == '0));

  assert_branch_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code[6:4]) == 3'b111) |-> (alu_res == '0));

  assert_taken_only_branch_R13: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> ($past(op_code[6:4]) == 3'b111 && !$past(op_code[0])));
endmodule

bind rv_bitalu rv_bitalu_checker u_rv_bitalu_checker (.*);

// File: tb/tb_rv_bitalu.sv
`timescale 1ns/1ps
module tb_rv_bitalu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_a = '0, src_b = '0;
  logic [6:0]  op_code = '0;
  logic [63:0] alu_res;
  logic        br_taken;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rv_bitalu dut (.clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b),
                 .op_code(op_code), .alu_res(alu_res), .br_taken(br_taken));

  function automatic logic [63:0] sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [63:0] rot64(input logic [63:0] a, input int s, input bit left);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[left ? (i + s) % 64 : (i + 64 - s) % 64] = a[i];
    return r;
  endfunction

  function automatic logic [31:0] rot32(input logic [31:0] a, input int s, input bit left);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[left ? (i + s) % 32 : (i + 32 - s) % 32] = a[i];
    return r;
  endfunction

  function automatic logic [63:0] orcb(input logic [63:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[8*i +: 8] != 0) ? 8'hFF : 8'h00;
    return r;
  endfunction

  // {taken, result}
  function automatic logic [64:0] ref_alu(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0, nv, uw;
    logic t = 1'b0;
    int s6 = int'(b[5:0]);
    int s5 = int'(b[4:0]);
    logic [31:0] ws = a[31:0] + b[31:0];
    uw = {32'h0, a[31:0]};
    case (op)
      7'b0000000: r = uw << s6;
      7'b0000001: r = a << s6;
      7'b0000010: begin r = a; r[s6] = 1'b0; end
      7'b0000011: begin r = a; r[s6] = 1'b1; end
      7'b0000100: begin r = a; r[s6] = ~a[s6]; end
      7'b0000101: r = a >> s6;
      7'b0000110: r = {63'h0, a[s6]};
      7'b0000111: r = 64'($signed(a) >>> s6);
      7'b0001001: r = rot64(a, s6, 1);
      7'b0001011: r = rot64(a, s6, 0);
      7'b0010000: r = sx32(ws);
      7'b0010001: r = sx32(32'(b[31:0] + 32'(a[0])));
      7'b0010010: r = sx32(a[31:0] - b[31:0]);
      7'b0010100: r = {63'h0, ws[0]};
      7'b0010101: r = {56'h0, ws[7:0]};
      7'b0010110: r = {48'h0, ws[15:0]};
      7'b0010111: r = {{48{ws[15]}}, ws[15:0]};
      7'b0011000: r = sx32(a[31:0] << s5);
      7'b0011001: r = sx32(a[31:0] >> s5);
      7'b0011010: r = sx32(32'($signed(a[31:0]) >>> s5));
      7'b0011100: r = sx32(rot32(a[31:0], s5, 1));
      7'b0011101: r = sx32(rot32(a[31:0], s5, 0));
      7'b0100000: r = uw + b;
      7'b0100001: r = a + b;
      7'b0100010: r = b + 64'(a[0]);
      7'b0100100, 7'b0100101, 7'b0100110, 7'b0100111: r = (a >> (29 + int'(op[1:0]))) + b;
      7'b0101000: r = uw * 2 + b;
      7'b0101001: r = a * 2 + b;
      7'b0101010: r = uw * 4 + b;
      7'b0101011: r = a * 4 + b;
      7'b0101100: r = uw * 8 + b;
      7'b0101101: r = a * 8 + b;
      7'b0101111: r = a * 16 + b;
      7'b0110000: r = a - b;
      7'b0110001: r = (a < b) ? 64'd1 : 64'd0;
      7'b0110010: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'b0110100: r = (a > b) ? a : b;
      7'b0110101: r = (a < b) ? a : b;
      7'b0110110: r = ($signed(a) > $signed(b)) ? a : b;
      7'b0110111: r = ($signed(a) < $signed(b)) ? a : b;
      7'b1000000: r = a & b;
      7'b1000001: r = a & ~b;
      7'b1000010: r = a | b;
      7'b1000011: r = a | ~b;
      7'b1000100: r = a ^ b;
      7'b1000101: r = a ^ ~b;
      7'b1000110: r = orcb(a);
      7'b1001000: r = {{56{a[7]}}, a[7:0]};
      7'b1001001: r = {48'h0, b[7:0], a[7:0]};
      7'b1001010: r = {{48{a[15]}}, a[15:0]};
      7'b1001011: r = sx32({b[15:0], a[15:0]});
      7'b1010000: for (int i = 0; i < 64; i++) r[i] = a[(i & ~7) | (7 - (i & 7))];
      7'b1010001: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*(7-i) +: 8];
      7'b1010010: r = {b[31:0], a[31:0]};
      7'b1100000, 7'b1100001, 7'b1100010, 7'b1100011,
      7'b1100100, 7'b1100101, 7'b1100110, 7'b1100111: begin
        case (op[2:1])
          2'd0: nv = a & b;
          2'd1: nv = a | b;
          2'd2: nv = a ^ b;
          default: nv = orcb(a);
        endcase
        r = op[0] ? {48'h0, nv[15:0]} : {63'h0, nv[0]};
      end
      7'b1110000: t = (a == b);
      7'b1110010: t = (a != b);
      7'b1111000: t = ($signed(a) < $signed(b));
      7'b1111010: t = ($signed(a) >= $signed(b));
      7'b1111100: t = (a < b);
      7'b1111110: t = (a >= b);
      default: r = '0;
    endcase
    return {t, r};
  endfunction

  function automatic string tag_of(input logic [6:0] op);
    logic [64:0] z = ref_alu(op, 64'h1, 64'h3);
    if (op[6:4] == 3'b111) return "R12";
    if (z == '0 && ref_alu(op, 64'hFFFF_0000_FFFF_0001, 64'h1234) == '0) return "R13";
    case (op[6:4])
      3'b000: return (op[3:0] inside {4'b0010, 4'b0011, 4'b0100, 4'b0110}) ? "R3" : "R2";
      3'b001: return (op[3:2] == 2'b01) ? "R5" : "R4";
      3'b010: return op[3] ? "R7" : "R6";
      3'b011: return "R8";
      3'b100: return op[3] ? "R10" : "R9";
      3'b101: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] exp = ref_alu(op, a, b);
    op_code = op; src_a = a; src_b = b;
    @(negedge clk);
    n_chk++;
    if (alu_res !== exp[63:0] || br_taken !== exp[64]) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h/%b expected=%h/%b",
               tag_of(op), op, a, b, alu_res, br_taken, exp[63:0], exp[64]);
    end
  endtask

  logic [6:0] codes [0:59];
  int n_codes = 0;

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1B));
    for (int c = 0; c < 128; c++)
      if (ref_alu(7'(c), 64'h8000_0000_FFFF_8181, 64'h7FFF_FFFF_0000_8123) != '0 ||
          ref_alu(7'(c), 64'h1, 64'h3) != '0 || c[6:4] == 3'b111) begin
        if (n_codes < 60) begin codes[n_codes] = 7'(c); n_codes++; end
      end
    // R1: reset state
    src_a = 64'hFFFF; src_b = 64'h1; op_code = 7'b0100001;
    repeat (3) @(negedge clk);
    n_chk++;
    if (alu_res !== '0 || br_taken !== 1'b0) begin
      n_bad++; $display("FAIL R1 actual=%h/%b expected=0/0", alu_res, br_taken);
    end
    rst = 1'b0;
    // Directed corners
    apply(7'b0000001, 64'h1, 64'd127);                      // R2 amount uses low 6 bits
    apply(7'b0001001, 64'h8000_0000_0000_0001, 64'd0);      // R2 rotate by 0
    apply(7'b0001011, 64'h8000_0000_0000_0001, 64'd65);    // R2
    apply(7'b0000110, 64'h8000_0000_0000_0000, 64'd63);    // R3 bext top bit
    apply(7'b0000010, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64);    // R3 index wraps to 0
    apply(7'b0011010, 64'h0000_0000_8000_0000, 64'd36);    // R4 sraw, amount low 5 bits
    apply(7'b0011000, 64'h0000_0000_4000_0001, 64'd33);    // R4 sllw
    apply(7'b0011101, 64'h0000_0000_0000_0001, 64'd1);     // R4 rorw
    apply(7'b0010111, 64'h0000_0000_0000_7FFF, 64'd1);     // R5 addwsexth
    apply(7'b0010100, 64'h1, 64'h1);                       // R5 addwbit
    apply(7'b0100111, 64'hFFFF_FFFF_0000_0000, 64'd1);     // R6 sr32add
    apply(7'b0100000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);     // R6 adduw
    apply(7'b0101111, 64'h1000_0000_0000_0001, 64'd5);     // R7 sh4add
    apply(7'b0101100, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);     // R7 sh3adduw
    apply(7'b0110010, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);     // R8 slt
    apply(7'b0110001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);     // R8 sltu
    apply(7'b0110111, 64'h8000_0000_0000_0000, 64'd1);     // R8 min
    apply(7'b1000011, 64'h0, 64'h00FF);                    // R9 orn
    apply(7'b1000110, 64'h0100_0000_0000_8000, 64'h0);     // R9 orcb
    apply(7'b1010001, 64'h0102_0304_0506_0708, 64'h0);     // R10 rev8
    apply(7'b1010000, 64'h0000_0000_0000_0001, 64'h0);     // R10 revb
    apply(7'b1001011, 64'h0000_0000_0000_1234, 64'h8000);  // R10 packw
    apply(7'b1100111, 64'h0000_0000_0001_0100, 64'h0);     // R11 orcb zext half
    apply(7'b1100100, 64'h3, 64'h1);                       // R11 xor lsb
    apply(7'b1111010, 64'h5, 64'h5);                       // R12 bge equal
    apply(7'b1111100, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF);     // R12 bltu
    apply(7'b1110000, 64'h7, 64'h7);                       // R12 beq
    apply(7'b1110100, 64'h7, 64'h7);                       // R13 unused compare type
    apply(7'b1110001, 64'h7, 64'h7);                       // R13 branch group bit0 set
    apply(7'b1111111, 64'h7, 64'h9);                       // R13
    apply(7'b0001000, 64'h7, 64'h9);                       // R13
    // Constrained random
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [6:0]  op;
      if ($urandom_range(0, 9) < 8) op = codes[$urandom_range(0, n_codes - 1)];
      else op = 7'($urandom);
      if ($urandom_range(0, 7) == 0) b = a;
      if ($urandom_range(0, 7) == 0) a = {$urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'h0, a[31:0]};
      apply(op, a, b);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule